// File: doc/BRIEF.md
# Size-Aware ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a small register-based processor. It takes a 32-bit source and a 32-bit destination operand, an operation code and a size select (byte, word or long). It returns the new destination value, a write-back strobe and the four condition flags negative (N), zero (Z), overflow (V) and carry (C), each with its own update strobe. All arithmetic is done on the low 8, 16 or 32 bits picked by the size select. Every flag is taken from the sign bit of that active width, so a byte add sets carry and overflow from bit 7 and not from bit 31.

The surrounding sequencer feeds the operands it has fetched, latches the result into the destination when the write strobe is high, and latches each flag whose strobe is high. Compare and test update the flags only. The quick forms take a 4-bit constant from the low nibble of the source port. No operation here touches the halt state of the processor, so the block has no halt output.

Top module: `sized_alu`

## Requirements
- R1: The size select i_size uses 2'b00 for byte (8 bits), 2'b01 for word (16 bits) and 2'b10 for long (32 bits). On every write, o_result bits above the active width equal the same bits of i_dst.
- R2: When a flag update is enabled, N equals the result bit at the active sign position (7, 15 or 31) and Z is 1 exactly when the low active bits of the result are all zero.
- R3: Add (i_op 0) and quick add (i_op 1) compute D+S. V is set when both operands share a sign that the result does not have. C is the carry out of the active sign bit.
- R4: Subtract (i_op 2), quick subtract (i_op 3) and compare (i_op 4) compute D−S. V is set when the operand signs differ and the result sign differs from D. C is set when S, taken unsigned at the active width, is greater than D.
- R5: Negate (i_op 5) computes 0−D. V is 1 only when D is the most negative value of the active width. C is 1 exactly when D is non-zero at that width.
- R6: Clear (i_op 6, result 0), invert (i_op 7, result ~D), and (i_op 8), or (i_op 9), exclusive-or (i_op 10), move (i_op 11, result S), quick move (i_op 12) and test (i_op 13, examines D) drive V and C to 0 and update N and Z from their sized result.
- R7: Compare (i_op 4) and test (i_op 13) hold o_wr_en at 0 while enabling all four flag updates.
- R8: The quick forms (i_op 1, 3, 12) use i_src[3:0] zero-extended to the active width as the source operand and ignore i_src[31:4].
- R9: Operation codes 14 and 15, and the size code 2'b11, give o_wr_en = 0 and all four flag enables 0.
- R10: Every valid operation with a valid size enables all four flag updates and settles within the same cycle as its inputs, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_op | input | 4 | Operation code (0..13 valid, 14..15 unused) |
| i_size | input | 2 | Operand size: 00 byte, 01 word, 10 long, 11 unused |
| i_src | input | 32 | Source operand S |
| i_dst | input | 32 | Destination operand D |
| o_result | output | 32 | New destination value; upper bits carried from i_dst |
| o_wr_en | output | 1 | Write the result back to the destination |
| o_n | output | 1 | New negative flag |
| o_z | output | 1 | New zero flag |
| o_v | output | 1 | New overflow flag |
| o_c | output | 1 | New carry flag |
| o_n_en | output | 1 | Update strobe for N |
| o_z_en | output | 1 | Update strobe for Z |
| o_v_en | output | 1 | Update strobe for V |
| o_c_en | output | 1 | Update strobe for C |

## Verification
The assertions assume the inputs are two-state and hold steady while they are evaluated. They relate the outputs to those inputs only under the sizes and codes that the requirements define, and they leave the unused codes to a separate quietness check. The bench changes the inputs only on the falling clock edge and samples one time unit later, so every check sees settled combinational values. Its operands sit on the sign and carry boundaries of each width (most negative value, all ones, zero, equal operands). Upper bits are set to non-zero patterns so that any leak across the size boundary shows at the port.

// File: rtl/salu_pkg.sv
// Package: shared encodings for the size-aware ALU.
// Assumes a 32-bit datapath with three operand widths (8, 16, 32).
package salu_pkg;
    localparam int DATA_W  = 32;
    localparam int N_SIZES = 3;
    localparam int OP_W    = 4;
    localparam int SIZE_W  = 2;
    localparam int QUICK_W = 4;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_NONE = 2'b11
    } size_e;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADDQ  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBQ  = 4'd3,
        OP_CMP   = 4'd4,
        OP_NEG   = 4'd5,
        OP_CLR   = 4'd6,
        OP_NOT   = 4'd7,
        OP_AND   = 4'd8,
        OP_OR    = 4'd9,
        OP_EOR   = 4'd10,
        OP_MOVE  = 4'd11,
        OP_MOVEQ = 4'd12,
        OP_TST   = 4'd13,
        OP_RSV0  = 4'd14,
        OP_RSV1  = 4'd15
    } op_e;

    // Which sign-bit equation set the flag unit applies.
    typedef enum logic [1:0] {
        FK_ADD   = 2'd0,
        FK_SUB   = 2'd1,
        FK_NEG   = 2'd2,
        FK_LOGIC = 2'd3
    } flag_kind_e;
endpackage

// File: rtl/salu_core.sv
// Module: salu_core
// Computes the raw full-width result of the selected operation and tells the
// flag unit which equation set applies. Assumes the caller applies sizing;
// this module works on the whole word and does not look at the size select.
module salu_core
    import salu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int QW = QUICK_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    src,
    input  logic [W-1:0]    dst,
    output logic [W-1:0]    raw,
    output logic [W-1:0]    s_used,
    output flag_kind_e      kind,
    output logic            op_ok,
    output logic            wr
);
    logic [W-1:0] quick;

    // Zero-extend the short constant carried in the source low bits.
    assign quick = {{(W-QW){1'b0}}, src[QW-1:0]};

    // Select operation, operand, flag equations and write intent.
    always_comb begin
        raw    = '0;
        s_used = src;
        kind   = FK_LOGIC;
        op_ok  = 1'b1;
        wr     = 1'b1;
        unique case (op_e'(op))
            OP_ADD:   begin raw = dst + src;   kind = FK_ADD; end
            OP_ADDQ:  begin raw = dst + quick; kind = FK_ADD; s_used = quick; end
            OP_SUB:   begin raw = dst - src;   kind = FK_SUB; end
            OP_SUBQ:  begin raw = dst - quick; kind = FK_SUB; s_used = quick; end
            OP_CMP:   begin raw = dst - src;   kind = FK_SUB; wr = 1'b0; end
            OP_NEG:   begin raw = '0 - dst;    kind = FK_NEG; end
            OP_CLR:   raw = '0;
            OP_NOT:   raw = ~dst;
            OP_AND:   raw = dst & src;
            OP_OR:    raw = dst | src;
            OP_EOR:   raw = dst ^ src;
            OP_MOVE:  raw = src;
            OP_MOVEQ: begin raw = quick; s_used = quick; end
            OP_TST:   begin raw = dst; wr = 1'b0; end
            default:  begin op_ok = 1'b0; wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/salu_size_view.sv
// Module: salu_size_view
// Builds the lane mask and sign-bit taps for the active operand width, merges
// the sized result over the destination and flags a zero result.
// Assumes widths are 8 << index and the widest equals W.
module salu_size_view
    import salu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NS = N_SIZES
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [W-1:0]      s,
    input  logic [W-1:0]      d,
    input  logic [W-1:0]      r,
    output logic              size_ok,
    output logic              sm,
    output logic              dm,
    output logic              rm,
    output logic              r_zero,
    output logic [W-1:0]      merged
);
    logic [W-1:0] lane_mask [NS];
    logic [W-1:0] sign_mask [NS];
    logic [W-1:0] mask;
    logic [W-1:0] sbit;

    // One mask and one sign tap per supported width.
    for (genvar g = 0; g < NS; g++) begin : g_lane
        localparam int LW = 8 << g;
        if (LW < W) begin : g_part
            assign lane_mask[g] = {{(W-LW){1'b0}}, {LW{1'b1}}};
        end else begin : g_full
            assign lane_mask[g] = {W{1'b1}};
        end
        assign sign_mask[g] = {{(W-1){1'b0}}, 1'b1} << (LW-1);
    end

    // Pick the mask for the requested width; unused size selects no lanes.
    always_comb begin
        size_ok = 1'b0;
        mask    = '0;
        sbit    = '0;
        for (int i = 0; i < NS; i++) begin
            if (size == SIZE_W'(i)) begin
                size_ok = 1'b1;
                mask    = lane_mask[i];
                sbit    = sign_mask[i];
            end
        end
    end

    // Tap sign bits at the moving position.
    assign sm = |(s & sbit);
    assign dm = |(d & sbit);
    assign rm = |(r & sbit);

    // Zero test and merge keep the bits above the active width from d.
    assign r_zero = ((r & mask) == '0);
    assign merged = (r & mask) | (d & ~mask);
endmodule

// File: rtl/salu_flag_eval.sv
// Module: salu_flag_eval
// Evaluates N, Z, V and C from the three sign bits and the zero test using
// explicit sign-bit equations. Assumes the inputs are already sized.
module salu_flag_eval
    import salu_pkg::*;
(
    input  flag_kind_e kind,
    input  logic       sm,
    input  logic       dm,
    input  logic       rm,
    input  logic       r_zero,
    output logic       n,
    output logic       z,
    output logic       v,
    output logic       c
);
    // Sign and zero flags follow the sized result directly.
    assign n = rm;
    assign z = r_zero;

    // Overflow and carry per equation set.
    always_comb begin
        unique case (kind)
            FK_ADD: begin
                v = (sm & dm & ~rm) | (~sm & ~dm & rm);
                c = (sm & dm) | (~rm & dm) | (sm & ~rm);
            end
            FK_SUB: begin
                v = (~sm & dm & ~rm) | (sm & ~dm & rm);
                c = (sm & ~dm) | (rm & ~dm) | (sm & rm);
            end
            FK_NEG: begin
                v = dm & rm;
                c = dm | rm;
            end
            default: begin
                v = 1'b0;
                c = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sized_alu.sv
// Module: sized_alu (top)
// Combinational size-aware ALU: operation core, size view and flag unit.
// Assumes the caller latches o_result when o_wr_en is high and latches each
// flag whose strobe is high. Holds no state, so it needs no clock or reset.
module sized_alu
    import salu_pkg::*;
(
    input  logic [3:0]  i_op,
    input  logic [1:0]  i_size,
    input  logic [31:0] i_src,
    input  logic [31:0] i_dst,
    output logic [31:0] o_result,
    output logic        o_wr_en,
    output logic        o_n,
    output logic        o_z,
    output logic        o_v,
    output logic        o_c,
    output logic        o_n_en,
    output logic        o_z_en,
    output logic        o_v_en,
    output logic        o_c_en
);
    logic [DATA_W-1:0] raw, s_used;
    flag_kind_e        kind;
    logic              op_ok, wr, size_ok, act;
    logic              sm, dm, rm, r_zero;
    logic              fn, fz, fv, fc;

    salu_core #(.W(DATA_W), .QW(QUICK_W)) u_core (
        .op(i_op), .src(i_src), .dst(i_dst),
        .raw(raw), .s_used(s_used), .kind(kind), .op_ok(op_ok), .wr(wr)
    );

    salu_size_view #(.W(DATA_W), .NS(N_SIZES)) u_view (
        .size(i_size), .s(s_used), .d(i_dst), .r(raw),
        .size_ok(size_ok), .sm(sm), .dm(dm), .rm(rm),
        .r_zero(r_zero), .merged(o_result)
    );

    salu_flag_eval u_flags (
        .kind(kind), .sm(sm), .dm(dm), .rm(rm), .r_zero(r_zero),
        .n(fn), .z(fz), .v(fv), .c(fc)
    );

    // An operation takes effect only with a known code and size.
    assign act = op_ok & size_ok;

    // Gate the write and flag strobes; flags read 0 when idle.
    assign o_wr_en = act & wr;
    assign o_n_en  = act;
    assign o_z_en  = act;
    assign o_v_en  = act;
    assign o_c_en  = act;
    assign o_n     = act & fn;
    assign o_z     = act & fz;
    assign o_v     = act & fv;
    assign o_c     = act & fc;
endmodule

// File: rtl/sized_alu_checker.sv
// Module: sized_alu_checker
// Immediate assertions on the ALU ports, bound to every sized_alu instance.
// Assumes two-state inputs that are stable while evaluated.
module sized_alu_checker (
    input logic [3:0]  i_op,
    input logic [1:0]  i_size,
    input logic [31:0] i_src,
    input logic [31:0] i_dst,
    input logic [31:0] o_result,
    input logic        o_wr_en,
    input logic        o_n,
    input logic        o_z,
    input logic        o_v,
    input logic        o_c,
    input logic        o_n_en,
    input logic        o_z_en,
    input logic        o_v_en,
    input logic        o_c_en
);
    logic        valid;
    logic        is_logic;
    logic [31:0] m;
    logic [31:0] top;

    // Decode the context the checks depend on.
    always_comb begin
        valid    = (i_op < 4'd14) && (i_size != 2'b11);
        is_logic = (i_op >= 4'd6) && (i_op <= 4'd13);
        m        = (i_size == 2'b00) ? 32'h0000_00FF :
                   (i_size == 2'b01) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        top      = (i_size == 2'b00) ? 32'h0000_0080 :
                   (i_size == 2'b01) ? 32'h0000_8000 : 32'h8000_0000;
    end

    // Port relations checked whenever the inputs settle.
    always_comb begin
        AST_UPPER_KEEP: assert (!o_wr_en || ((o_result & ~m) == (i_dst & ~m)));                 // R1
        AST_ZERO_MATCH: assert (!(o_z_en && o_wr_en) || (o_z == ((o_result & m) == 32'h0)));    // R2
        AST_SIGN_MATCH: assert (!(o_n_en && o_wr_en) || (o_n == ((o_result & top) != 32'h0)));  // R2
        AST_NEG_CARRY:  assert (!(valid && i_op == 4'd5) || (o_c == ((i_dst & m) != 32'h0)));   // R5
        AST_LOGIC_VC:   assert (!(valid && is_logic) || (!o_v && !o_c));                        // R6
        AST_NO_WRITE:   assert (!(i_op == 4'd4 || i_op == 4'd13) || !o_wr_en);                  // R7
        AST_QUIET:      assert (valid || !(o_wr_en | o_n_en | o_z_en | o_v_en | o_c_en));       // R9
        AST_ALL_EN:     assert (!valid || (o_n_en && o_z_en && o_v_en && o_c_en));              // R10
    end

    // Fold the remaining inputs so every port is observed.
    logic unused_ok;
    assign unused_ok = ^{i_src, o_n, o_z, o_v, o_c};
endmodule

bind sized_alu sized_alu_checker u_chk (
    .i_op(i_op), .i_size(i_size), .i_src(i_src), .i_dst(i_dst),
    .o_result(o_result), .o_wr_en(o_wr_en),
    .o_n(o_n), .o_z(o_z), .o_v(o_v), .o_c(o_c),
    .o_n_en(o_n_en), .o_z_en(o_z_en), .o_v_en(o_v_en), .o_c_en(o_c_en)
);

// File: tb/sim_sized_alu.sv
// Directed bench for sized_alu with an independent reference model.
module sim_sized_alu;
    localparam logic [3:0] C_ADD = 4'd0, C_ADDQ = 4'd1, C_SUB = 4'd2, C_SUBQ = 4'd3,
                           C_CMP = 4'd4, C_NEG = 4'd5, C_CLR = 4'd6, C_NOT = 4'd7,
                           C_AND = 4'd8, C_OR = 4'd9, C_EOR = 4'd10, C_MOVE = 4'd11,
                           C_MOVEQ = 4'd12, C_TST = 4'd13;
    localparam logic [1:0] SB = 2'b00, SW = 2'b01, SL = 2'b10, SX = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd14;
    logic [1:0]  size = 2'b00;
    logic [31:0] src = '0;
    logic [31:0] dst = '0;
    logic [31:0] res;
    logic        we, fn, fz, fv, fc, en_n, en_z, en_v, en_c;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sized_alu u0 (
        .i_op(op), .i_size(size), .i_src(src), .i_dst(dst),
        .o_result(res), .o_wr_en(we),
        .o_n(fn), .o_z(fz), .o_v(fv), .o_c(fc),
        .o_n_en(en_n), .o_z_en(en_z), .o_v_en(en_v), .o_c_en(en_c)
    );

    // Reference model built from the requirement text.
    task automatic model(input logic [3:0] o, input logic [1:0] sz,
                         input logic [31:0] s, input logic [31:0] d,
                         output logic [31:0] er, output logic ew,
                         output logic [3:0] ef, output logic [3:0] een);
        int w;
        logic [31:0] m, msb, a, b, r;
        logic [32:0] t;
        logic v, c;
        w   = (sz == SB) ? 8 : (sz == SW) ? 16 : 32;
        m   = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        msb = 32'h1 << (w - 1);
        a   = (o == C_ADDQ || o == C_SUBQ || o == C_MOVEQ) ? {28'h0, s[3:0]} : (s & m);
        b   = d & m;
        v = 1'b0; c = 1'b0; r = '0;
        case (o)
            C_ADD, C_ADDQ: begin
                t = {1'b0, a} + {1'b0, b};
                r = t[31:0] & m;
                c = t[w];
                v = ((a & msb) == (b & msb)) && ((r & msb) != (a & msb));
            end
            C_SUB, C_SUBQ, C_CMP: begin
                r = (b - a) & m;
                c = a > b;
                v = ((a & msb) != (b & msb)) && ((r & msb) != (b & msb));
            end
            C_NEG: begin
                r = (32'h0 - b) & m;
                c = b != 0;
                v = b == msb;
            end
            C_CLR:            r = '0;
            C_NOT:            r = ~b & m;
            C_AND:            r = a & b;
            C_OR:             r = a | b;
            C_EOR:            r = a ^ b;
            C_MOVE, C_MOVEQ:  r = a;
            C_TST:            r = b;
            default:          r = '0;
        endcase
        er  = r | (d & ~m);
        ef  = {(r & msb) != 0, r == 0, v, c};
        if (o >= 4'd14 || sz == SX) begin
            ew = 1'b0; een = 4'b0000;
        end else begin
            ew = !(o == C_CMP || o == C_TST); een = 4'b1111;
        end
    endtask

    // Apply one vector, wait for settling, compare against the model.
    task automatic check_vec(input string tag, input logic [3:0] o, input logic [1:0] sz,
                             input logic [31:0] s, input logic [31:0] d);
        logic [31:0] er; logic ew; logic [3:0] ef, een, af, aen;
        bit bad;
        @(negedge clk);
        op = o; size = sz; src = s; dst = d;
        #1;
        model(o, sz, s, d, er, ew, ef, een);
        af  = {fn, fz, fv, fc};
        aen = {en_n, en_z, en_v, en_c};
        bad = (we !== ew) || (aen !== een) || (ew && res !== er) ||
              ((af & een) !== (ef & een));
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s op=%0d size=%0d: got res=%h we=%b nzvc=%b en=%b, expected res=%h we=%b nzvc=%b en=%b",
                     tag, o, sz, res, we, af, aen, er, ew, ef, een);
        end
    endtask

    task automatic t_reset;   // R9: quiet outputs while held in reset with an unused code
        check_vec("R9 reset idle", 4'd14, SB, 32'h0, 32'h0);
    endtask

    task automatic t_add;     // R1 R2 R3
        check_vec("R3 byte overflow", C_ADD, SB, 32'h0000_0001, 32'hAABB_CC7F);
        check_vec("R3 byte carry zero", C_ADD, SB, 32'h1234_5601, 32'hAABB_CCFF);
        check_vec("R3 word V and C", C_ADD, SW, 32'h0000_8000, 32'h5555_8000);
        check_vec("R3 long wrap", C_ADD, SL, 32'h0000_0001, 32'hFFFF_FFFF);
        check_vec("R1 upper keep word", C_ADD, SW, 32'hFFFF_0001, 32'hDEAD_0002);
    endtask

    task automatic t_sub;     // R4 R7
        check_vec("R4 byte borrow", C_SUB, SB, 32'h0000_0001, 32'h1111_1100);
        check_vec("R4 word overflow", C_SUB, SW, 32'h0000_0001, 32'h0000_8000);
        check_vec("R4 long no borrow", C_SUB, SL, 32'h0000_0003, 32'h0000_0007);
        check_vec("R7 compare equal", C_CMP, SL, 32'h8000_0000, 32'h8000_0000);
        check_vec("R7 compare byte less", C_CMP, SB, 32'h0000_0090, 32'h0000_0010);
    endtask

    task automatic t_neg;     // R5
        check_vec("R5 neg byte min", C_NEG, SB, 32'h0, 32'hFFFF_FF80);
        check_vec("R5 neg word zero", C_NEG, SW, 32'hFFFF_FFFF, 32'h1234_0000);
        check_vec("R5 neg long one", C_NEG, SL, 32'h0, 32'h0000_0001);
    endtask

    task automatic t_logic;   // R6 R7 R2
        check_vec("R6 clear word", C_CLR, SW, 32'h0, 32'h1234_5678);
        check_vec("R6 invert byte", C_NOT, SB, 32'h0, 32'h0000_00FF);
        check_vec("R6 and long", C_AND, SL, 32'hF0F0_F0F0, 32'hFF00_FF00);
        check_vec("R6 or byte", C_OR, SB, 32'h0000_0080, 32'h7777_7701);
        check_vec("R6 eor word", C_EOR, SW, 32'h0000_ABCD, 32'h0000_ABCD);
        check_vec("R6 move byte", C_MOVE, SB, 32'h1234_56F0, 32'hAAAA_AAAA);
        check_vec("R7 test long negative", C_TST, SL, 32'h0, 32'h8000_0001);
        check_vec("R2 test byte zero", C_TST, SB, 32'h0, 32'hFFFF_FF00);
    endtask

    task automatic t_quick;   // R8
        check_vec("R8 quick add ignores upper src", C_ADDQ, SB, 32'hFFFF_FFF3, 32'h0000_0010);
        check_vec("R8 quick sub to borrow", C_SUBQ, SW, 32'hABCD_EF08, 32'h9999_0004);
        check_vec("R8 quick move", C_MOVEQ, SL, 32'h8000_000F, 32'hFFFF_FFFF);
    endtask

    task automatic t_unused;  // R9
        check_vec("R9 code 14", 4'd14, SL, 32'h1, 32'h1);
        check_vec("R9 code 15", 4'd15, SB, 32'h80, 32'h80);
        check_vec("R9 size 11", C_ADD, SX, 32'h1, 32'hFF);
    endtask

    task automatic t_sweep;   // R10 plus R1..R8 on pseudo-random operands
        logic [31:0] lf = 32'hACE1_2345;
        logic [31:0] lg = 32'h1357_9BDF;
        for (int k = 0; k < 420; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lg = {lg[30:0], lg[31] ^ lg[21] ^ lg[1] ^ lg[0]};
            check_vec("R10 sweep", 4'(k % 14), 2'(k % 3), lf, lg);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        @(negedge clk) rst_n = 1'b1;
        t_add;
        t_sub;
        t_neg;
        t_logic;
        t_quick;
        t_unused;
        t_sweep;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule